// File: doc/BRIEF.md
# Flash Power-Up Command Gate

This block sits between the instruction decoder of a serial flash memory and the logic that carries out instructions. It decides, for every decoded opcode, whether the opcode is accepted or dropped while the supply ramps up, settles and possibly sags again. Two digital flags from the supply comparators are its inputs. The first says the rail is above the write-inhibit level. The second says the rail is at or above the minimum operating level. Both flags are synchronized into the clock domain before any use.

Two cycle-counting delays control two separate gates. The read gate opens once the rail has been at operating level for the select delay. The write gate also waits for the write-inhibit delay. Opcodes that program, erase or arm writing pass only through the write gate. All other opcodes pass through the read gate. While the rail is below the write-inhibit level, or while the external reset is low, everything is held in its power-on state: standby (not deep power-down), write-enable latch cleared, both gates shut and every opcode dropped.

The block also holds the write-enable latch and the deep power-down flag, because their power-on value is part of what the gate enforces.

Top module: `pwrup_cmd_gate`

## Requirements
- R1: The threshold inputs pass through a two-flop synchronizer. While the synchronized write-inhibit flag is low, both gates are closed, every valid opcode is answered with `op_ignore_o`, and `wel_o` and `deep_pd_o` are 0 from the next clock edge onward.
- R2: The write class is the opcode set 06h, 0Ah, 02h, DBh, D8h, C7h and E5h. A write-class opcode is accepted only while `wr_open_o` is 1. Every other opcode is read class and is accepted only while `rd_open_o` is 1.
- R3: `rd_open_o` is 1 after clock edge n exactly when both threshold inputs were sampled high on at least SEL_CYCLES+1 consecutive edges ending at edge n-1.
- R4: `wr_open_o` is 1 exactly when `rd_open_o` is 1 and the write-inhibit input was sampled high on at least WI_CYCLES+1 consecutive edges ending at edge n-1. The write class is therefore released at the later of the two delays.
- R5: An opcode presented with `op_valid_i` high at edge n gives exactly one of `op_accept_o` or `op_ignore_o` high for the one cycle after edge n. With no valid opcode, both outputs are 0.
- R6: `wel_o` is 0 after power-up. An accepted 06h sets it. An accepted 04h clears it. It changes at the same edge that raises `op_accept_o`.
- R7: `deep_pd_o` is 0 after power-up, which is standby. An accepted B9h sets it. While it is 1, every opcode except ABh is ignored. An accepted ABh clears it.
- R8: A low on the write-inhibit input closes both gates two edges later and restarts both delays. A low on the operating-level input closes both gates two edges later and restarts only the select delay.
- R9: A low on `rst_n` immediately and asynchronously forces the R1 state and restarts both delays.
- R10: `ready_o` is 1 exactly when both gates are open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_wi_ok_i | input | 1 | Supply above write-inhibit level (asynchronous) |
| supply_min_ok_i | input | 1 | Supply at or above minimum operating level (asynchronous) |
| op_valid_i | input | 1 | A decoded opcode is presented this cycle |
| op_code_i | input | 8 | Decoded opcode |
| op_accept_o | output | 1 | Previous-cycle opcode accepted |
| op_ignore_o | output | 1 | Previous-cycle opcode dropped |
| rd_open_o | output | 1 | Read-class gate open |
| wr_open_o | output | 1 | Write-class gate open |
| ready_o | output | 1 | Both gates open |
| wel_o | output | 1 | Write-enable latch |
| deep_pd_o | output | 1 | Deep power-down flag (0 = standby) |

## Verification
The assertions assume that the threshold flags are arbitrary levels that only reach the logic through the synchronizer. They also assume that `op_code_i` is meaningful only in cycles where `op_valid_i` is high. Under these assumptions, the response and latch properties can be stated one edge after the decode. The stimulus changes every input at the falling clock edge. It sweeps the relative rise times of the two flags across and beyond both delays, and inserts short sags on each flag so that the gates reopen. Throughout, it feeds a rotating mix of write-class, read-class, power-down and release opcodes, so that each gate is probed in every state.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_DPD     = 8'hB9;
  localparam logic [7:0] OP_RELEASE = 8'hAB;

  // write-class membership: opcodes that arm, program, erase or lock
  function automatic logic is_write_op(input logic [7:0] op);
    case (op)
      8'h06, 8'h0A, 8'h02, 8'hDB, 8'hD8, 8'hC7, 8'hE5: return 1'b1;
      default:                                           return 1'b0;
    endcase
  endfunction

  // counter width able to hold 0..limit
  function automatic int cnt_bits(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_o <= '0;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/pcg_delay.sv
module pcg_delay #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int W = pcg_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run_i)      cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIM);
endmodule

// File: rtl/pcg_cmd_filter.sv
module pcg_cmd_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       rd_open_i,
  input  logic       wr_open_i,
  input  logic       op_valid_i,
  input  logic [7:0] op_code_i,
  output logic       is_write_o,
  output logic       take_o,
  output logic       accept_o,
  output logic       ignore_o,
  output logic       wel_o,
  output logic       deep_pd_o
);
  import pcg_pkg::*;

  logic gate_ok;

  always_comb begin
    is_write_o = is_write_op(op_code_i);
    gate_ok    = is_write_o ? wr_open_i : rd_open_i;
    if (deep_pd_o && (op_code_i != OP_RELEASE)) gate_ok = 1'b0;
    take_o     = op_valid_i && gate_ok && !hold_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o  <= 1'b0;
      ignore_o  <= 1'b0;
      wel_o     <= 1'b0;
      deep_pd_o <= 1'b0;
    end else if (hold_i) begin
      accept_o  <= 1'b0;
      ignore_o  <= op_valid_i;
      wel_o     <= 1'b0;
      deep_pd_o <= 1'b0;
    end else begin
      accept_o <= take_o;
      ignore_o <= op_valid_i && !take_o;
      if (take_o) begin
        case (op_code_i)
          OP_WREN:    wel_o     <= 1'b1;
          OP_WRDI:    wel_o     <= 1'b0;
          OP_DPD:     deep_pd_o <= 1'b1;
          OP_RELEASE: deep_pd_o <= 1'b0;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwrup_cmd_gate.sv
module pwrup_cmd_gate #(
  parameter int WI_CYCLES  = 1000,
  parameter int SEL_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_wi_ok_i,
  input  logic       supply_min_ok_i,
  input  logic       op_valid_i,
  input  logic [7:0] op_code_i,
  output logic       op_accept_o,
  output logic       op_ignore_o,
  output logic       rd_open_o,
  output logic       wr_open_o,
  output logic       ready_o,
  output logic       wel_o,
  output logic       deep_pd_o
);
  logic [1:0] sync_bus;
  logic       sync_wi;
  logic       sync_min;
  logic       sel_run;
  logic       wi_done;
  logic       sel_done;
  logic       is_write;
  logic       take;

  pcg_sync #(.WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({supply_min_ok_i, supply_wi_ok_i}),
    .sync_o (sync_bus)
  );

  assign sync_wi  = sync_bus[0];
  assign sync_min = sync_bus[1];
  assign sel_run  = sync_wi && sync_min;

  pcg_delay #(.LIMIT(WI_CYCLES)) u_wi_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (sync_wi),
    .done_o(wi_done)
  );

  pcg_delay #(.LIMIT(SEL_CYCLES)) u_sel_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (sel_run),
    .done_o(sel_done)
  );

  assign rd_open_o = sel_run && sel_done;
  assign wr_open_o = rd_open_o && wi_done;
  assign ready_o   = rd_open_o && wr_open_o;

  pcg_cmd_filter u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (!sync_wi),
    .rd_open_i (rd_open_o),
    .wr_open_i (wr_open_o),
    .op_valid_i(op_valid_i),
    .op_code_i (op_code_i),
    .is_write_o(is_write),
    .take_o    (take),
    .accept_o  (op_accept_o),
    .ignore_o  (op_ignore_o),
    .wel_o     (wel_o),
    .deep_pd_o (deep_pd_o)
  );
endmodule

// File: rtl/pwrup_cmd_gate_chk.sv
module pwrup_cmd_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_wi,
  input logic       sync_min,
  input logic       is_write,
  input logic       op_valid_i,
  input logic [7:0] op_code_i,
  input logic       op_accept_o,
  input logic       op_ignore_o,
  input logic       rd_open_o,
  input logic       wr_open_o,
  input logic       wel_o,
  input logic       deep_pd_o
);
  p_held_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_wi |-> (!rd_open_o && !wr_open_o));

  p_held_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_wi |=> (!wel_o && !deep_pd_o && !op_accept_o));

  p_write_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && is_write && !wr_open_o) |=> op_ignore_o);

  p_read_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_open_o) |-> ($past(sync_wi) && $past(sync_min)));

  p_write_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open_o |-> rd_open_o);

  p_one_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> $onehot({op_accept_o, op_ignore_o}));

  p_no_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> (!op_accept_o && !op_ignore_o));

  p_wel_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> (op_accept_o && ($past(op_code_i) == 8'h06)));

  p_dpd_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && deep_pd_o && (op_code_i != 8'hAB)) |=> op_ignore_o);
endmodule

bind pwrup_cmd_gate pwrup_cmd_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_wi    (sync_wi),
  .sync_min   (sync_min),
  .is_write   (is_write),
  .op_valid_i (op_valid_i),
  .op_code_i  (op_code_i),
  .op_accept_o(op_accept_o),
  .op_ignore_o(op_ignore_o),
  .rd_open_o  (rd_open_o),
  .wr_open_o  (wr_open_o),
  .wel_o      (wel_o),
  .deep_pd_o  (deep_pd_o)
);

// File: tb/sim_pwrup_cmd_gate.sv
`timescale 1ns/1ps
module sim_pwrup_cmd_gate;
  localparam int WI  = 12;
  localparam int SEL = 5;
  localparam int RUN_CAP = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vwi = 1'b0, vmin = 1'b0, val = 1'b0;
  logic [7:0] op = 8'h00;
  logic acc, ign, rdo, wro, rdy, wel, dpd;

  always #5 clk = ~clk;

  pwrup_cmd_gate #(.WI_CYCLES(WI), .SEL_CYCLES(SEL)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_wi_ok_i(vwi), .supply_min_ok_i(vmin),
    .op_valid_i(val), .op_code_i(op), .op_accept_o(acc), .op_ignore_o(ign),
    .rd_open_o(rdo), .wr_open_o(wro), .ready_o(rdy), .wel_o(wel), .deep_pd_o(dpd)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // bench model: run lengths of high samples, latest edge and the one before
  int cur_v = 0, prev_v = 0, cur_b = 0, prev_b = 0;
  bit wel_m = 0, dpd_m = 0;

  function automatic bit wr_class(input logic [7:0] c);
    return (c == 8'h06) || (c == 8'h0A) || (c == 8'h02) || (c == 8'hDB) ||
           (c == 8'hD8) || (c == 8'hC7) || (c == 8'hE5);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    cur_v = 0; prev_v = 0; cur_b = 0; prev_b = 0; wel_m = 0; dpd_m = 0;
  endtask

  task automatic step(input bit v, input bit m, input bit ov, input logic [7:0] oc,
                      input bit in_drop);
    bit synced, rd_g, wr_g, gate, exp_acc;
    vwi = v; vmin = m; val = ov; op = oc;
    synced = (prev_v > 0);
    rd_g   = (prev_b >= SEL + 1);
    wr_g   = rd_g && (prev_v >= WI + 1);
    gate   = wr_class(oc) ? wr_g : rd_g;
    if (dpd_m && oc != 8'hAB) gate = 0;
    exp_acc = ov && synced && gate;
    if (!synced) begin
      wel_m = 0; dpd_m = 0;
    end else if (exp_acc) begin
      case (oc)
        8'h06: wel_m = 1;
        8'h04: wel_m = 0;
        8'hB9: dpd_m = 1;
        8'hAB: dpd_m = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    prev_v = cur_v; cur_v = v ? ((cur_v < RUN_CAP) ? cur_v + 1 : cur_v) : 0;
    prev_b = cur_b; cur_b = (v && m) ? ((cur_b < RUN_CAP) ? cur_b + 1 : cur_b) : 0;
    @(negedge clk);
    rd_g = (prev_b >= SEL + 1);
    wr_g = rd_g && (prev_v >= WI + 1);
    if (!synced) chk("R1 ignore while held", ign, ov);
    if (wr_class(oc)) chk("R2 write-class accept", acc, exp_acc);
    else              chk("R2 read-class accept", acc, exp_acc);
    chk("R5 exactly one answer", ign, ov && !exp_acc);
    chk("R6 write-enable latch", wel, wel_m);
    chk("R7 deep power-down flag", dpd, dpd_m);
    if (in_drop) begin
      chk("R8 read gate after sag", rdo, rd_g);
      chk("R8 write gate after sag", wro, wr_g);
    end else begin
      chk("R3 read gate", rdo, rd_g);
      chk("R4 write gate", wro, wr_g);
    end
    chk("R10 ready", rdy, rd_g && wr_g);
  endtask

  function automatic logic [7:0] op_pick(input int k);
    case (k % 16)
      0: return 8'h06;  1: return 8'h03;  2: return 8'h02;  3: return 8'h05;
      4: return 8'h0A;  5: return 8'hB9;  6: return 8'h06;  7: return 8'hAB;
      8: return 8'hD8;  9: return 8'h04; 10: return 8'hDB; 11: return 8'h9F;
     12: return 8'h06; 13: return 8'hC7; 14: return 8'hE5; default: return 8'h0B;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R9 reset clears accept", acc, 1'b0);
    chk("R9 reset clears ignore", ign, 1'b0);
    chk("R9 reset closes read gate", rdo, 1'b0);
    chk("R9 reset closes write gate", wro, 1'b0);
    chk("R9 reset clears latch", wel, 1'b0);
    chk("R9 reset gives standby", dpd, 1'b0);
    model_clear();
    @(posedge clk);
    @(negedge clk);
    model_clear();
    rst_n = 1;
  endtask

  // each scenario: rise times ta/tb, optional sags on either flag
  task automatic scenario(input int ta, input int tb, input int sag_v, input int sag_m,
                          input int len, input int seed);
    for (int c = 0; c < len; c++) begin
      bit v, m, ov, drop;
      v  = (c >= ta) && !(sag_v > 0 && c >= sag_v && c < sag_v + 3);
      m  = (c >= tb) && !(sag_m > 0 && c >= sag_m && c < sag_m + 4);
      ov = ((c + seed) % 5) != 4;
      drop = (sag_v > 0 && c >= sag_v) || (sag_m > 0 && c >= sag_m);
      step(v, m, ov, op_pick(c + seed), drop);
    end
    for (int c = 0; c < 4; c++) step(0, 0, 1, op_pick(c), 1'b0);
  endtask

  initial begin
    #1;
    chk("R9 accept low in reset", acc, 1'b0);
    chk("R7 standby in reset", dpd, 1'b0);
    chk("R6 latch low in reset", wel, 1'b0);
    @(negedge clk);
    rst_n = 1;
    model_clear();
    for (int off = 0; off <= 20; off++) scenario(0, off, 0, 0, 45, off);
    for (int off = 1; off <= 10; off++) scenario(off, 0, 0, 0, 45, off + 3);
    for (int s = 20; s <= 26; s++) scenario(0, 2, s, 0, 60, s);
    for (int s = 16; s <= 22; s++) scenario(0, 0, 0, s, 60, s + 1);
    // asynchronous reset in the middle of open operation
    for (int c = 0; c < 30; c++) step(1, 1, 1, op_pick(c), 1'b0);
    do_reset();
    for (int c = 0; c < 30; c++) step(1, 1, 1, op_pick(c + 5), 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule